// File: doc/BRIEF.md
# Radix-4 Add-Compare-Select Unit

This unit advances the path metric of one trellis state in a Viterbi decoder by two radix-2 trellis steps in a single clock. Each cycle it receives four predecessor path metrics and the four radix-4 branch metrics that go with them. It forms the four candidate sums and selects the smallest. It then registers the new path metric together with a 2-bit decision that identifies the winning predecessor.

Path metrics are kept in wrap-around arithmetic. Additions drop their carry, and comparisons look at the sign of a modular difference. Because of this the unit needs no rescaling logic, as long as all live metrics stay within half the modular range of one another. Those metrics have to begin from values that respect the trellis, so the unit accepts a synchronous load of an initial metric instead of assuming zero. A valid strobe gates every register update.

Top module: `radix4_acs`

## Requirements
- R1: While `rst_n` is low, `metric_q` and `dec_q` are both zero.
- R2: Candidate i is `pm_in[i*MW +: MW]` plus the zero-extended `bm_in[i*BW +: BW]`, taken modulo 2^MW. The carry out of the addition is discarded.
- R3: Candidate a counts as smaller than candidate b exactly when bit MW-1 of (a - b) mod 2^MW is 1. With `in_valid` high and `load` low, `metric_q` becomes the candidate that is minimal under this rule.
- R4: When several candidates tie for the minimum, the one with the lowest index wins.
- R5: `dec_q` carries the binary index (0 to 3) of the winning candidate. It is registered on the same edge as the metric it belongs to.
- R6: When `in_valid` and `load` are both high, the next edge sets `metric_q` to `init_metric` and `dec_q` to 0. This happens no matter what the candidates are.
- R7: When `in_valid` is low, both outputs hold their values, even if `load` is high.
- R8: Results appear exactly one clock edge after the inputs that produce them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Enables the register update for this cycle |
| load | input | 1 | Loads `init_metric` in place of the add-compare-select result |
| init_metric | input | MW | Initial path metric |
| pm_in | input | 4*MW | Four predecessor metrics; entry i is at bits [i*MW +: MW] |
| bm_in | input | 4*BW | Four branch metrics; entry i is at bits [i*BW +: BW] |
| metric_q | output | MW | Registered new path metric |
| dec_q | output | 2 | Registered index of the winning predecessor |

## Verification
A load and a regular update can both be requested in the same cycle. The bench provokes this by raising `load` while presenting candidates whose minimum differs from `init_metric`. It then expects the loaded value and a zero decision. The bench also pairs `load` with a low `in_valid` and expects the outputs to stay frozen. Separately, it drives candidate sets that straddle the wrap point and sets that contain ties, and it checks each cycle against a behavioural integer model.

// File: rtl/radix4_acs.sv
module radix4_acs #(
  parameter int MW = 8,
  parameter int BW = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             load,
  input  logic [MW-1:0]    init_metric,
  input  logic [4*MW-1:0]  pm_in,
  input  logic [4*BW-1:0]  bm_in,
  output logic [MW-1:0]    metric_q,
  output logic [1:0]       dec_q
);

  localparam int NC = 4;

  function automatic logic mod_less(input logic [MW-1:0] a, input logic [MW-1:0] b);
    logic [MW-1:0] d;
    d = a - b;
    return d[MW-1];
  endfunction

  logic [MW-1:0] cand [NC];

  for (genvar i = 0; i < NC; i++) begin : g_add
    assign cand[i] = pm_in[i*MW +: MW] + {{(MW-BW){1'b0}}, bm_in[i*BW +: BW]};
  end

  logic          w01, w23, hi;
  logic [MW-1:0] v01, v23;
  logic [1:0]    win;
  logic [MW-1:0] best;

  assign w01  = mod_less(cand[1], cand[0]);
  assign w23  = mod_less(cand[3], cand[2]);
  assign v01  = w01 ? cand[1] : cand[0];
  assign v23  = w23 ? cand[3] : cand[2];
  assign hi   = mod_less(v23, v01);
  assign win  = hi ? {1'b1, w23} : {1'b0, w01};
  assign best = cand[win];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      metric_q <= '0;
      dec_q    <= '0;
    end else if (in_valid) begin
      if (load) begin
        metric_q <= init_metric;
        dec_q    <= '0;
      end else begin
        metric_q <= best;
        dec_q    <= win;
      end
    end
  end

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(metric_q) && $stable(dec_q));

  // R6
  load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && load |=> metric_q == $past(init_metric) && dec_q == 2'd0);

  // R5
  dec_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !load |=> metric_q == (dec_q == 2'd0 ? $past(cand[0]) :
                                       dec_q == 2'd1 ? $past(cand[1]) :
                                       dec_q == 2'd2 ? $past(cand[2]) : $past(cand[3])));

  // R3
  minimal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !load |=> !mod_less($past(cand[0]), metric_q) && !mod_less($past(cand[1]), metric_q)
                       && !mod_less($past(cand[2]), metric_q) && !mod_less($past(cand[3]), metric_q));

  // R4
  tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !load |=> (dec_q < 2'd1 || mod_less(metric_q, $past(cand[0])))
                       && (dec_q < 2'd2 || mod_less(metric_q, $past(cand[1])))
                       && (dec_q < 2'd3 || mod_less(metric_q, $past(cand[2]))));

  // R1
  always_comb if (!rst_n) rst_chk: assert (metric_q == '0 && dec_q == 2'd0);

endmodule

// File: tb/radix4_acs_tb.sv
module radix4_acs_tb_top;
  localparam int MW = 8;
  localparam int BW = 5;
  localparam int MOD = 1 << MW;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, load = 1'b0;
  logic [MW-1:0] init_metric = '0;
  logic [4*MW-1:0] pm_in = '0;
  logic [4*BW-1:0] bm_in = '0;
  logic [MW-1:0] metric_q;
  logic [1:0] dec_q;

  int n_run = 0, n_fail = 0;
  int exp_m = 0, exp_d = 0;
  bit done = 0;

  always #4 clk = ~clk;

  radix4_acs #(.MW(MW), .BW(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .load(load),
    .init_metric(init_metric), .pm_in(pm_in), .bm_in(bm_in),
    .metric_q(metric_q), .dec_q(dec_q));

  function automatic bit ref_less(int a, int b);
    return ((a - b + MOD) % MOD) >= MOD / 2;
  endfunction

  task automatic check(string req);
    n_run++;
    if (int'(metric_q) != exp_m || int'(dec_q) != exp_d) begin
      n_fail++;
      $display("FAIL %s: metric=%0d dec=%0d expected metric=%0d dec=%0d",
               req, metric_q, dec_q, exp_m, exp_d);
    end
  endtask

  task automatic step(bit v, bit ld, int init, int pm[4], int bm[4], string req);
    int best, bi;
    @(negedge clk);
    in_valid = v; load = ld; init_metric = MW'(init);
    for (int i = 0; i < 4; i++) begin
      pm_in[i*MW +: MW] = MW'(pm[i]);
      bm_in[i*BW +: BW] = BW'(bm[i]);
    end
    if (v) begin
      if (ld) begin
        exp_m = init % MOD; exp_d = 0;
      end else begin
        best = (pm[0] + bm[0]) % MOD; bi = 0;
        for (int i = 1; i < 4; i++) begin
          int c = (pm[i] + bm[i]) % MOD;
          if (ref_less(c, best)) begin best = c; bi = i; end
        end
        exp_m = best; exp_d = bi;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  initial begin
    int pm[4], bm[4];
    repeat (3) @(negedge clk);
    exp_m = 0; exp_d = 0;
    check("R1");
    rst_n = 1'b1;

    // R2 R5 R8: plain update, winner at index 2
    pm = '{40, 30, 10, 50}; bm = '{1, 2, 3, 4};
    step(1, 0, 0, pm, bm, "R2");
    // R3: candidate 0 wraps past zero (250+10 -> 4) but 3 is smaller
    pm = '{250, 3, 20, 9}; bm = '{10, 0, 0, 0};
    step(1, 0, 0, pm, bm, "R3");
    // R3: wrapped candidate is the true minimum among values near the top
    pm = '{240, 250, 255, 245}; bm = '{20, 31, 5, 30};
    step(1, 0, 0, pm, bm, "R3");
    // R4: full tie picks index 0
    pm = '{7, 7, 7, 7}; bm = '{3, 3, 3, 3};
    step(1, 0, 0, pm, bm, "R4");
    // R4: tie between 1 and 3
    pm = '{20, 5, 30, 4}; bm = '{0, 2, 0, 3};
    step(1, 0, 0, pm, bm, "R4");
    // R4: tie between 2 and 3 across wrap
    pm = '{100, 100, 255, 254}; bm = '{0, 0, 2, 3};
    step(1, 0, 0, pm, bm, "R4");
    // R6: load wins over a concurrent update
    pm = '{1, 1, 1, 1}; bm = '{0, 0, 0, 0};
    step(1, 1, 77, pm, bm, "R6");
    // R7: valid low with load high is ignored
    step(0, 1, 200, pm, bm, "R7");
    // R7: valid low with candidates is ignored
    pm = '{0, 0, 0, 0};
    step(0, 0, 0, pm, bm, "R7");
    // R5: winner at index 3
    pm = '{60, 61, 62, 10}; bm = '{0, 0, 0, 0};
    step(1, 0, 0, pm, bm, "R5");

    for (int n = 0; n < 400; n++) begin
      int base = $urandom_range(0, MOD - 1);
      for (int i = 0; i < 4; i++) begin
        pm[i] = (base + $urandom_range(0, 63)) % MOD;
        bm[i] = $urandom_range(0, (1 << BW) - 1);
      end
      case ($urandom_range(0, 9))
        0: step(1, 1, $urandom_range(0, MOD - 1), pm, bm, "R6");
        1: step(0, $urandom_range(0, 1), 0, pm, bm, "R7");
        default: step(1, 0, 0, pm, bm, "R3");
      endcase
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: run did not complete");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule